// File: doc/BRIEF.md
# Digital Phase Frequency Detector with Antibacklash Overlap

This block compares two divided pulse trains, a reference pulse and a feedback pulse, and drives the UP and DOWN controls of a charge pump. Both inputs are sampled on a fast system clock. A rising edge on the reference sets UP, and a rising edge on the feedback sets DOWN. The difference between the two pulse widths, counted in system-clock cycles, tracks the phase and frequency error between the inputs.

When UP and DOWN are both set, a programmable overlap counter runs. When it expires, both flops clear on the same clock edge. Both outputs therefore pulse for at least the programmed overlap on every comparison, so the transfer function has no dead zone near zero phase error. An edge that lands in the clearing cycle is held and applied one cycle later, so it is not lost. A registered sign output reports which input led in the most recent comparison.

Top module: `pfd_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears UP, DOWN, the sign output, any held edges, the overlap counter and the input history. After reset, only a new rising edge can set a flop.
- R2: A reference input that was sampled low at one edge and is high at the next edge sets `up_o` at that next edge. `up_o` stays high until the overlap clear.
- R3: A feedback input that was sampled low at one edge and is high at the next edge sets `dn_o` at that next edge. `dn_o` stays high until the overlap clear.
- R4: Once `up_o` and `dn_o` are both high, they stay high together for exactly N cycles, where N is `abl_cycles`, and then both fall on the same edge. With zero phase error, each output is therefore high for exactly N cycles.
- R5: An `abl_cycles` value of 0 acts as an overlap of 1 cycle.
- R6: A rising edge detected on the same clock edge as the clear is held. It sets its flop on the following clock edge.
- R7: On every edge where exactly one of `up_o`/`dn_o` is high, `ref_lead_o` takes the value 1 if that output is `up_o` and 0 if it is `dn_o`. On all other edges it holds its value.
- R8: A rising edge on an input whose flop is already set, or an input held high, has no further effect. The flop does not pulse a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Divided reference pulse |
| fb_i | input | 1 | Divided feedback pulse |
| abl_cycles | input | DLY_W | Overlap length in clock cycles (0 acts as 1) |
| up_o | output | 1 | Charge-pump UP control |
| dn_o | output | 1 | Charge-pump DOWN control |
| ref_lead_o | output | 1 | 1 when the reference led the last comparison |

## Verification
On every cycle, the in-line assertions check four things: an edge sets its flop, a set flop holds until cleared, the overlap counter stays consistent with the clear, and both outputs drop together. They also check that an edge landing on the clear re-appears one cycle later and that the sign follows whichever single output is high. The exact pulse widths can only be shown by the bench scenarios, because each width is the sum of a lead time and the programmed overlap. These scenarios cover zero phase error, a leading reference, a leading feedback, an overlap of zero, a held edge and a redundant edge. The bench scenarios also show that a reset in the middle of a comparison leaves no trace.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   localparam int CH_REF = 0;
   localparam int CH_FB  = 1;
   localparam int NUM_CH = 2;

   // Which outputs are currently asserted: {dn, up}
   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_UP   = 2'b01,
      ST_DN   = 2'b10,
      ST_BOTH = 2'b11
   } pfd_state_e;
endpackage

// File: rtl/pfd_chan.sv
module pfd_chan (
   input  logic clk,
   input  logic rst,
   input  logic in_i,
   input  logic clr_i,
   output logic q_o
);
   logic in_q;
   logic pend_q;
   logic edge_w;

   assign edge_w = in_i & ~in_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         in_q   <= 1'b0;
         pend_q <= 1'b0;
         q_o    <= 1'b0;
      end else begin
         in_q <= in_i;
         if (clr_i) begin
            q_o    <= 1'b0;
            pend_q <= edge_w;
         end else begin
            q_o    <= q_o | edge_w | pend_q;
            pend_q <= 1'b0;
         end
      end
   end

   // R2 R3
   set_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_w && !clr_i) |=> q_o);

   // R8
   hold_until_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (q_o && !clr_i) |=> q_o);

   // R6
   pend_replay_chk: assert property (@(posedge clk) disable iff (rst)
      (edge_w && clr_i) |=> (!q_o ##1 q_o));
endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             both_i,
   input  logic [DLY_W-1:0] limit_i,
   output logic             clr_o
);
   logic [DLY_W-1:0] cnt_q;
   logic [DLY_W-1:0] lim_eff;

   assign lim_eff = (limit_i == '0) ? DLY_W'(1) : limit_i;
   assign clr_o   = both_i && (cnt_q == lim_eff - DLY_W'(1));

   always_ff @(posedge clk) begin
      if (rst || !both_i || clr_o) cnt_q <= '0;
      else                         cnt_q <= cnt_q + DLY_W'(1);
   end

   // R4
   cnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
      (both_i && !clr_o) |=> (cnt_q != '0));

   // R4
   cnt_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      clr_o |=> (cnt_q == '0));
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
   parameter int DLY_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_i,
   input  logic             fb_i,
   input  logic [DLY_W-1:0] abl_cycles,
   output logic             up_o,
   output logic             dn_o,
   output logic             ref_lead_o
);
   import pfd_pkg::*;

   generate
      if (DLY_W < 1 || DLY_W > 16) begin : g_bad_w
         $error("pfd_core: DLY_W must lie in 1..16");
      end
   endgenerate

   logic [NUM_CH-1:0] ch_in;
   logic [NUM_CH-1:0] ch_q;
   logic              both_w;
   logic              clr_w;
   pfd_state_e        state;

   assign ch_in[CH_REF] = ref_i;
   assign ch_in[CH_FB]  = fb_i;

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_ch
         pfd_chan u_chan (
            .clk   (clk),
            .rst   (rst),
            .in_i  (ch_in[g]),
            .clr_i (clr_w),
            .q_o   (ch_q[g])
         );
      end
   endgenerate

   assign both_w = &ch_q;

   pfd_abl_timer #(.DLY_W(DLY_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .both_i  (both_w),
      .limit_i (abl_cycles),
      .clr_o   (clr_w)
   );

   assign up_o  = ch_q[CH_REF];
   assign dn_o  = ch_q[CH_FB];
   assign state = pfd_state_e'({ch_q[CH_FB], ch_q[CH_REF]});

   always_ff @(posedge clk) begin
      if (rst) ref_lead_o <= 1'b0;
      else begin
         case (state)
            ST_UP:   ref_lead_o <= 1'b1;
            ST_DN:   ref_lead_o <= 1'b0;
            default: ref_lead_o <= ref_lead_o;
         endcase
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!up_o && !dn_o && !ref_lead_o));

   // R4
   joint_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (up_o && dn_o && clr_w) |=> (!up_o && !dn_o));

   // R7
   sign_up_chk: assert property (@(posedge clk) disable iff (rst)
      (up_o && !dn_o) |=> ref_lead_o);

   // R7
   sign_dn_chk: assert property (@(posedge clk) disable iff (rst)
      (dn_o && !up_o) |=> !ref_lead_o);
endmodule

// File: tb/sim_pfd_core.sv
`timescale 1ns/1ps
module sim_pfd_core;
   localparam int DLY_W = 6;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             ref_i = 1'b0;
   logic             fb_i = 1'b0;
   logic [DLY_W-1:0] abl_cycles = '0;
   logic             up_o, dn_o, ref_lead_o;

   int vecs = 0;
   int errs = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pfd_core #(.DLY_W(DLY_W)) u0 (
      .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
      .abl_cycles(abl_cycles), .up_o(up_o), .dn_o(dn_o),
      .ref_lead_o(ref_lead_o)
   );

   // behavioural reference model
   bit m_up, m_dn, m_pu, m_pd, m_sign, m_pr, m_pf;
   int m_ov;
   always @(posedge clk) begin
      bit er, ef, clr;
      int lim;
      if (rst) begin
         m_up = 0; m_dn = 0; m_pu = 0; m_pd = 0; m_sign = 0;
         m_pr = 0; m_pf = 0; m_ov = 0;
      end else begin
         er = ref_i && !m_pr;
         ef = fb_i && !m_pf;
         m_pr = ref_i; m_pf = fb_i;
         lim = (abl_cycles == 0) ? 1 : int'(abl_cycles);
         if (m_up != m_dn) m_sign = m_up;
         clr = m_up && m_dn && (m_ov + 1 >= lim);
         if (clr) begin
            m_up = 0; m_dn = 0; m_pu = er; m_pd = ef; m_ov = 0;
         end else begin
            m_ov = (m_up && m_dn) ? m_ov + 1 : 0;
            m_up = m_up || er || m_pu; m_pu = 0;
            m_dn = m_dn || ef || m_pd; m_pd = 0;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cmp_model();
      vecs++;
      if (up_o !== m_up || dn_o !== m_dn || ref_lead_o !== m_sign) begin
         errs++;
         $display("FAIL R2/R3/R4/R7 per-cycle: actual up=%b dn=%b lead=%b expected up=%b dn=%b lead=%b",
                  up_o, dn_o, ref_lead_o, m_up, m_dn, m_sign);
      end
   endtask

   // bit i of a pattern is the input level driven before clock edge i
   task automatic run(input logic [31:0] rp, input logic [31:0] fp,
                      output int uc, output int dc);
      uc = 0; dc = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         cmp_model();
         if (up_o) uc++;
         if (dn_o) dc++;
         ref_i = (i < 32) ? rp[i] : 1'b0;
         fb_i  = (i < 32) ? fp[i] : 1'b0;
      end
   endtask

   initial begin
      int uc, dc;
      repeat (4) @(negedge clk);
      // R1: state out of reset
      chk("R1 up after reset", up_o, 0);
      chk("R1 dn after reset", dn_o, 0);
      chk("R1 lead after reset", ref_lead_o, 0);
      rst = 1'b0;

      // R4: zero phase error, overlap 3
      abl_cycles = 6'd3;
      run(32'h1, 32'h1, uc, dc);
      chk("R4 zero-phase up width", uc, 3);
      chk("R4 zero-phase dn width", dc, 3);

      // R2: reference leads by 5, overlap 3
      run(32'h1, 32'h20, uc, dc);
      chk("R2 ref-lead up width", uc, 8);
      chk("R2 ref-lead dn width", dc, 3);
      chk("R7 sign after ref lead", ref_lead_o, 1);

      // R3: feedback leads by 4, overlap 1
      abl_cycles = 6'd1;
      run(32'h10, 32'h1, uc, dc);
      chk("R3 fb-lead up width", uc, 1);
      chk("R3 fb-lead dn width", dc, 5);
      chk("R7 sign after fb lead", ref_lead_o, 0);

      // R5: overlap 0 behaves as 1
      abl_cycles = 6'd0;
      run(32'h1, 32'h1, uc, dc);
      chk("R5 zero setting up width", uc, 1);
      chk("R5 zero setting dn width", dc, 1);

      // R6: reference edge on the clearing edge is held
      abl_cycles = 6'd2;
      run(32'h5, 32'h401, uc, dc);
      chk("R6 held edge up width", uc, 11);
      chk("R6 held edge dn width", dc, 4);

      // R8: second ref edge while UP set, and a held-high input
      run(32'h9, 32'h40, uc, dc);
      chk("R8 redundant edge up width", uc, 8);
      chk("R8 redundant edge dn width", dc, 2);
      run(32'hFFFF, 32'h8, uc, dc);
      chk("R8 level-high up width", uc, 5);
      chk("R8 level-high dn width", dc, 2);
      chk("R8 up idle afterwards", up_o, 0);

      // R1: reset in mid-comparison
      run(32'h1, 32'h0, uc, dc);
      chk("R1 up set before mid reset", up_o, 1);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R1 up after mid reset", up_o, 0);
      chk("R1 lead after mid reset", ref_lead_o, 0);
      rst = 1'b0;
      abl_cycles = 6'd1;
      run(32'h8, 32'h1, uc, dc);
      chk("R1 post-reset up width", uc, 1);
      chk("R1 post-reset dn width", dc, 4);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end
endmodule